// File: doc/BRIEF.md
# HDLC Transmit FIFO and Status Logic

This block holds the bytes a host queues for an HDLC serial transmitter and produces the transmit-side flags of an eight-bit, clear-on-read interrupt status register. The host pushes bytes into a 128-entry FIFO. The serial transmitter pulls them out one strobe at a time and reports two things with single-cycle pulses: that a closing flag has been sent, and that an abort sequence has been sent. Framing, bit stuffing and CRC generation happen elsewhere.

The status register holds sticky flags. It raises a flag when the FIFO level drops below a programmable low mark, when the transmitter strobes an empty FIFO, and when a packet completes or is aborted. One status position is shared between a received frame-abort event and the transmit underrun event, and a select input decides which of the two reaches it. The receive-side flags sit in their fixed positions and are set by event inputs from the receiver. Reading the register clears every flag. A maskable interrupt line summarises the flags.

Top module: `hdlc_tx_stat`

## Requirements
- R1: After a synchronous reset the FIFO is empty, `stat_out` is 8'h00, `irq` is low and `tx_rd_valid` is low.
- R2: Bytes leave the FIFO in the order they were written. A read strobe on a non-empty FIFO gives `tx_rd_valid` high with the byte on `tx_rd_data` in the following cycle.
- R3: The FIFO holds 128 bytes. A write to a full FIFO is dropped, so after 130 writes the first 128 bytes come out and the 129th read finds the FIFO empty.
- R4: Bit 3 of `stat_out` is set when an accepted read takes the FIFO level from at least `low_thresh` to below it. A further read that stays below the mark does not set it again, and writes never set it.
- R5: With `sel_underrun` = 1, a read strobe on an empty FIFO sets bit 2 of `stat_out`, and `tx_rd_valid` stays low in the following cycle.
- R6: With `sel_underrun` = 0, bit 2 is set by `rx_abort_evt` and an empty-FIFO read leaves it clear. With `sel_underrun` = 1, `rx_abort_evt` leaves bit 2 clear.
- R7: Bit 5 of `stat_out` is set by a `tx_flag_done` pulse and also by a `tx_abort_done` pulse.
- R8: A `stat_rd` pulse clears every status bit at the next clock edge. An event that arrives in the same cycle as the read is kept.
- R9: The receive event inputs map to fixed positions: `rx_evt[4]` to bit 7 (go-ahead), `rx_evt[3]` to bit 6 (receive end of packet), `rx_evt[2]` to bit 4 (last byte read), `rx_evt[1]` to bit 1 (receive FIFO full) and `rx_evt[0]` to bit 0 (receive overflow).
- R10: `irq` is high exactly when some bit of `stat_out` is 1 and the same bit of `irq_mask` is 0. It follows a change of `irq_mask` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_data | input | 8 | Byte written by the host |
| tx_rd_en | input | 1 | Transmitter read strobe |
| tx_rd_data | output | 8 | Byte delivered to the transmitter |
| tx_rd_valid | output | 1 | `tx_rd_data` holds a byte from the previous strobe |
| tx_flag_done | input | 1 | Pulse: closing flag sent |
| tx_abort_done | input | 1 | Pulse: abort sequence sent |
| rx_abort_evt | input | 1 | Pulse: frame abort received |
| rx_evt | input | 5 | Pulses for the receive-side status positions |
| sel_underrun | input | 1 | 0: bit 2 reports receive abort; 1: bit 2 reports underrun |
| low_thresh | input | 8 | FIFO low mark in bytes |
| stat_rd | input | 1 | Status register read strobe (clears all flags) |
| stat_out | output | 8 | Status register contents |
| irq_mask | input | 8 | Per-bit interrupt mask, 1 suppresses |
| irq | output | 1 | Interrupt request |

## Verification
Every event input, read strobe and clear strobe acts on one register stage. Its effect therefore shows on `stat_out` and `tx_rd_valid`/`tx_rd_data` in the cycle after the edge that samples it, and the bench drives inputs just after one rising edge and checks outputs just after the next one. `irq` is combinational from the flags and the mask, so after a mask change it is checked in the same cycle, before any further edge. The low-mark checks hold the level just above, at and below the mark, so that the cycle of the crossing, and the absence of a second one, are each observed.

// File: rtl/hdlc_txs_pkg.sv
package hdlc_txs_pkg;

    localparam int STAT_W = 8;
    localparam int RXE_W  = 5;

    // Status register bit positions (order fixed by the register layout)
    localparam int B_GOAHEAD = 7;
    localparam int B_RXEOP   = 6;
    localparam int B_TXEOP   = 5;
    localparam int B_EOPRD   = 4;
    localparam int B_TXLOW   = 3;
    localparam int B_ABUR    = 2;
    localparam int B_RXFULL  = 1;
    localparam int B_RXOVF   = 0;

    typedef enum logic {
        SEL_RXABORT  = 1'b0,
        SEL_UNDERRUN = 1'b1
    } ab_sel_e;

    // Transmit-side events found in one cycle
    typedef struct packed {
        logic tx_eop;
        logic tx_low;
        logic shared;
    } tx_evt_t;

    function automatic logic [STAT_W-1:0] place_events(
        input tx_evt_t          tev,
        input logic [RXE_W-1:0] rxe
    );
        logic [STAT_W-1:0] v;
        v = '0;
        v[B_GOAHEAD] = rxe[4];
        v[B_RXEOP]   = rxe[3];
        v[B_TXEOP]   = tev.tx_eop;
        v[B_EOPRD]   = rxe[2];
        v[B_TXLOW]   = tev.tx_low;
        v[B_ABUR]    = tev.shared;
        v[B_RXFULL]  = rxe[1];
        v[B_RXOVF]   = rxe[0];
        return v;
    endfunction

endpackage

// File: rtl/txs_fifo.sv
module txs_fifo #(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    input  logic             rd_en,
    output logic [DW-1:0]    rd_data,
    output logic             rd_valid,
    output logic             rd_accept,
    output logic             empty,
    output logic [CNT_W-1:0] level,
    output logic [CNT_W-1:0] level_nx
);

    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             full, wr_accept;

    assign empty     = (level == '0);
    assign full      = (level == FULL_LVL);
    assign wr_accept = wr_en && !full;
    assign rd_accept = rd_en && !empty;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        level_nx = level;
        unique case ({wr_accept, rd_accept})
            2'b10:   level_nx = level + 1'b1;
            2'b01:   level_nx = level - 1'b1;
            default: level_nx = level;
        endcase
    end

    always_ff @(posedge clk) begin
        if (wr_accept) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            level    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            level    <= level_nx;
            rd_valid <= rd_accept;
            if (wr_accept) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (rd_accept) begin
                rd_ptr  <= bump(rd_ptr);
                rd_data <= mem[rd_ptr];
            end
        end
    end

    // R3: level never exceeds the depth
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        level <= FULL_LVL);

    // R3: a write into a full FIFO with no read leaves it full, nothing lost or added
    a_r3_full_drop: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full && !rd_en) |=> (level == FULL_LVL));

    // R2: a strobe on a non-empty FIFO yields a valid byte next cycle
    a_r2_valid_after_read: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !empty) |=> rd_valid);

    // R5: a strobe on an empty FIFO yields no byte
    a_r5_no_valid_on_empty: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty) |=> !rd_valid);

endmodule

// File: rtl/txs_events.sv
module txs_events
    import hdlc_txs_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic               rd_en,
    input  logic               rd_accept,
    input  logic               empty,
    input  logic [CNT_W-1:0]   level,
    input  logic [CNT_W-1:0]   level_nx,
    input  logic [CNT_W-1:0]   low_mark,
    input  logic               flag_done,
    input  logic               abort_done,
    input  logic               rx_abort,
    input  ab_sel_e            sel,
    input  logic [RXE_W-1:0]   rx_evt,
    output logic [STAT_W-1:0]  set_vec
);

    tx_evt_t tev;
    logic    crossing, underrun;

    // Edge detect on the level: above-or-at before, below after, caused by a read
    assign crossing = rd_accept && (level >= low_mark) && (level_nx < low_mark);
    assign underrun = rd_en && empty;

    always_comb begin
        tev.tx_eop = flag_done || abort_done;
        tev.tx_low = crossing;
        unique case (sel)
            SEL_UNDERRUN: tev.shared = underrun;
            default:      tev.shared = rx_abort;
        endcase
    end

    assign set_vec = place_events(tev, rx_evt);

endmodule

// File: rtl/txs_stat_reg.sv
module txs_stat_reg
    import hdlc_txs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] set_vec,
    input  logic              clr,
    input  logic [STAT_W-1:0] mask,
    output logic [STAT_W-1:0] stat,
    output logic              irq
);

    logic [STAT_W-1:0] keep;

    assign keep = clr ? '0 : stat;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else begin
            stat <= keep | set_vec;
        end
    end

    assign irq = |(stat & ~mask);

    // R8: a read with no concurrent event empties the register
    a_r8_clear_on_read: assert property (@(posedge clk) disable iff (rst)
        (clr && (set_vec == '0)) |=> (stat == '0));

    // R8: an event arriving with a read survives it
    a_r8_event_kept: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((stat & $past(set_vec)) == $past(set_vec)));

    // R10: no flags, no interrupt
    a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
        (stat == '0) |-> !irq);

endmodule

// File: rtl/hdlc_tx_stat.sv
module hdlc_tx_stat
    import hdlc_txs_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr_en,
    input  logic [DW-1:0]     host_wr_data,
    input  logic              tx_rd_en,
    output logic [DW-1:0]     tx_rd_data,
    output logic              tx_rd_valid,
    input  logic              tx_flag_done,
    input  logic              tx_abort_done,
    input  logic              rx_abort_evt,
    input  logic [RXE_W-1:0]  rx_evt,
    input  logic              sel_underrun,
    input  logic [CNT_W-1:0]  low_thresh,
    input  logic              stat_rd,
    output logic [STAT_W-1:0] stat_out,
    input  logic [STAT_W-1:0] irq_mask,
    output logic              irq
);

    logic              rd_accept, fifo_empty;
    logic [CNT_W-1:0]  level, level_nx;
    logic [STAT_W-1:0] set_vec;
    ab_sel_e           sel;

    assign sel = sel_underrun ? SEL_UNDERRUN : SEL_RXABORT;

    txs_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (host_wr_en),
        .wr_data   (host_wr_data),
        .rd_en     (tx_rd_en),
        .rd_data   (tx_rd_data),
        .rd_valid  (tx_rd_valid),
        .rd_accept (rd_accept),
        .empty     (fifo_empty),
        .level     (level),
        .level_nx  (level_nx)
    );

    txs_events #(.CNT_W(CNT_W)) u_events (
        .rd_en      (tx_rd_en),
        .rd_accept  (rd_accept),
        .empty      (fifo_empty),
        .level      (level),
        .level_nx   (level_nx),
        .low_mark   (low_thresh),
        .flag_done  (tx_flag_done),
        .abort_done (tx_abort_done),
        .rx_abort   (rx_abort_evt),
        .sel        (sel),
        .rx_evt     (rx_evt),
        .set_vec    (set_vec)
    );

    txs_stat_reg u_stat (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr     (stat_rd),
        .mask    (irq_mask),
        .stat    (stat_out),
        .irq     (irq)
    );

    // R5: underrun mode, empty read raises bit 2
    a_r5_underrun: assert property (@(posedge clk) disable iff (rst)
        (sel_underrun && tx_rd_en && fifo_empty) |=> stat_out[B_ABUR]);

    // R6: receive-abort mode, abort pulse raises bit 2
    a_r6_rx_abort: assert property (@(posedge clk) disable iff (rst)
        (!sel_underrun && rx_abort_evt) |=> stat_out[B_ABUR]);

    // R7: end of packet from either completion pulse
    a_r7_tx_eop: assert property (@(posedge clk) disable iff (rst)
        (tx_flag_done || tx_abort_done) |=> stat_out[B_TXEOP]);

    // R4: a read that moves the level under the mark raises bit 3
    a_r4_low_cross: assert property (@(posedge clk) disable iff (rst)
        (rd_accept && (level >= low_thresh) && (level_nx < low_thresh))
        |=> stat_out[B_TXLOW]);

    // R9: go-ahead event lands on bit 7
    a_r9_goahead: assert property (@(posedge clk) disable iff (rst)
        rx_evt[4] |=> stat_out[B_GOAHEAD]);

endmodule

// File: tb/hdlc_tx_stat_tb_top.sv
`timescale 1ns/1ps
module hdlc_tx_stat_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       host_wr_en;
    logic [7:0] host_wr_data;
    logic       tx_rd_en;
    logic [7:0] tx_rd_data;
    logic       tx_rd_valid;
    logic       tx_flag_done;
    logic       tx_abort_done;
    logic       rx_abort_evt;
    logic [4:0] rx_evt;
    logic       sel_underrun;
    logic [7:0] low_thresh;
    logic       stat_rd;
    logic [7:0] stat_out;
    logic [7:0] irq_mask;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    hdlc_tx_stat dut_i (
        .clk(clk), .rst(rst),
        .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
        .tx_rd_en(tx_rd_en), .tx_rd_data(tx_rd_data), .tx_rd_valid(tx_rd_valid),
        .tx_flag_done(tx_flag_done), .tx_abort_done(tx_abort_done),
        .rx_abort_evt(rx_abort_evt), .rx_evt(rx_evt),
        .sel_underrun(sel_underrun), .low_thresh(low_thresh),
        .stat_rd(stat_rd), .stat_out(stat_out),
        .irq_mask(irq_mask), .irq(irq)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        host_wr_en = 1'b1; host_wr_data = b;
        cyc();
        host_wr_en = 1'b0;
    endtask

    task automatic pop_expect(input string tag, input logic [7:0] exp);
        tx_rd_en = 1'b1;
        cyc();
        tx_rd_en = 1'b0;
        chk({tag, " valid"}, tx_rd_valid, 1);
        chk({tag, " data"}, tx_rd_data, exp);
    endtask

    task automatic clear_stat();
        stat_rd = 1'b1;
        cyc();
        stat_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 stat", stat_out, 8'h00);
        chk("R1 irq", irq, 0);
        chk("R1 valid", tx_rd_valid, 0);
    endtask

    task automatic t_order();
        push(8'hA5); push(8'h3C); push(8'hF0);
        pop_expect("R2 b0", 8'hA5);
        pop_expect("R2 b1", 8'h3C);
        pop_expect("R2 b2", 8'hF0);
        chk("R2 no flags", stat_out, 8'h00);
    endtask

    task automatic t_low();
        low_thresh = 8'd4;
        for (int i = 0; i < 6; i++) push(8'h10 + 8'(i));
        chk("R4 writes no low", stat_out, 8'h00);
        pop_expect("R4 p0", 8'h10);
        pop_expect("R4 p1", 8'h11);
        chk("R4 at mark", stat_out, 8'h00);
        pop_expect("R4 p2", 8'h12);
        chk("R4 crossed", stat_out, 8'h08);
        clear_stat();
        pop_expect("R4 p3", 8'h13);
        chk("R4 stays below no reset", stat_out, 8'h00);
        pop_expect("R4 p4", 8'h14);
        pop_expect("R4 p5", 8'h15);
        chk("R4 drained", stat_out, 8'h00);
    endtask

    task automatic t_underrun();
        sel_underrun = 1'b1;
        tx_rd_en = 1'b1;
        cyc();
        tx_rd_en = 1'b0;
        chk("R5 valid low", tx_rd_valid, 0);
        chk("R5 bit2", stat_out, 8'h04);
        chk("R10 irq on", irq, 1);
        clear_stat();
        chk("R8 cleared", stat_out, 8'h00);
    endtask

    task automatic t_select();
        sel_underrun = 1'b0;
        tx_rd_en = 1'b1;
        cyc();
        tx_rd_en = 1'b0;
        chk("R6 underrun ignored", stat_out, 8'h00);
        rx_abort_evt = 1'b1;
        cyc();
        rx_abort_evt = 1'b0;
        chk("R6 rx abort", stat_out, 8'h04);
        clear_stat();
        sel_underrun = 1'b1;
        rx_abort_evt = 1'b1;
        cyc();
        rx_abort_evt = 1'b0;
        chk("R6 rx abort ignored", stat_out, 8'h00);
    endtask

    task automatic t_eop();
        tx_flag_done = 1'b1;
        cyc();
        tx_flag_done = 1'b0;
        chk("R7 flag done", stat_out, 8'h20);
        clear_stat();
        tx_abort_done = 1'b1;
        cyc();
        tx_abort_done = 1'b0;
        chk("R7 abort done", stat_out, 8'h20);
        clear_stat();
    endtask

    task automatic t_clear();
        rx_evt = 5'b10000;
        cyc();
        rx_evt = '0;
        chk("R8 pre", stat_out, 8'h80);
        stat_rd = 1'b1; tx_abort_done = 1'b1;
        cyc();
        stat_rd = 1'b0; tx_abort_done = 1'b0;
        chk("R8 event kept", stat_out, 8'h20);
        clear_stat();
        chk("R8 empty", stat_out, 8'h00);
    endtask

    task automatic t_layout();
        logic [7:0] pos [5];
        pos[0] = 8'h01; pos[1] = 8'h02; pos[2] = 8'h10; pos[3] = 8'h40; pos[4] = 8'h80;
        for (int i = 0; i < 5; i++) begin
            rx_evt = 5'(1 << i);
            cyc();
            rx_evt = '0;
            chk($sformatf("R9 rx_evt[%0d]", i), stat_out, pos[i]);
            clear_stat();
        end
    endtask

    task automatic t_irq();
        tx_flag_done = 1'b1;
        cyc();
        tx_flag_done = 1'b0;
        irq_mask = 8'h20; #1;
        chk("R10 masked", irq, 0);
        irq_mask = 8'hDF; #1;
        chk("R10 other bits masked", irq, 1);
        irq_mask = 8'h00; #1;
        chk("R10 unmasked", irq, 1);
        clear_stat();
        chk("R10 off after clear", irq, 0);
    endtask

    task automatic t_full();
        sel_underrun = 1'b1;
        low_thresh = 8'd4;
        for (int i = 0; i < 130; i++) push(8'(i));
        for (int i = 0; i < 128; i++) begin
            tx_rd_en = 1'b1;
            cyc();
            tx_rd_en = 1'b0;
            chk("R3 valid", tx_rd_valid, 1);
            chk("R3 data", tx_rd_data, 32'(8'(i)));
        end
        tx_rd_en = 1'b1;
        cyc();
        tx_rd_en = 1'b0;
        chk("R3 extra read empty", tx_rd_valid, 0);
        chk("R3 low and underrun", stat_out, 8'h0C);
        clear_stat();
    endtask

    initial begin
        rst = 1'b1;
        host_wr_en = 0; host_wr_data = 0; tx_rd_en = 0;
        tx_flag_done = 0; tx_abort_done = 0; rx_abort_evt = 0; rx_evt = 0;
        sel_underrun = 1; low_thresh = 8'd4; stat_rd = 0; irq_mask = 0;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        t_reset();
        t_order();
        t_low();
        t_underrun();
        t_select();
        t_eop();
        t_clear();
        t_layout();
        t_irq();
        t_full();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule